// File: doc/BRIEF.md
# Packing DAC Sample Queue with Channel Tags

This block is the write-side front end of a digital-to-analog converter controller. Software writes 32-bit words to one data port. Each write is split into one or two 16-bit sample entries, and the entries are queued in a four-deep FIFO. Each queued entry carries a 12-bit conversion code and a 2-bit output channel number. The channel comes either from tag bits inside the sample or from a default channel field. A downstream conversion sequencer drains the queue through a valid/ready handshake.

In half-word mode a write yields one entry, taken from bits [15:0]. In word mode a write yields two entries: bits [15:0] are queued first and converted first, and bits [31:16] follow. The channel number is resolved when the entry is pushed, so the entry keeps it even if the mode inputs change later. A ready flag tells software when a write will be accepted. A write made while that flag is low does not touch the queue; it sets a sticky error flag, which only reset clears.

Occupancy is tracked by a controller state machine with three states. `ST_EMPTY` means no entries are held. `ST_PART` means one to DEPTH-1 entries are held. `ST_FULL` means DEPTH entries are held. The next state comes from the occupancy after the cycle's push and pop:

- `T_FILL` takes `ST_EMPTY` to `ST_PART`, or straight to `ST_FULL` when DEPTH is at most 2.
- `T_TOP` takes `ST_PART` to `ST_FULL`.
- `T_DRAIN` takes `ST_FULL` or `ST_PART` down to a state with fewer entries.
- `T_HOLD` keeps the current state.

Synchronous reset forces `ST_EMPTY`.

Top module: `dac_sample_frontend`

## Requirements
- R1: While `rst` is high at a clock edge, the queue empties and the error flag clears. After that edge `out_valid`=0 and `wr_error`=0, and `tx_ready`=1 if `conv_enable`=1.
- R2: In half-word mode (`cfg_word_mode`=0), an accepted write pushes exactly one entry, whose code is `wr_data[11:0]`. Bits [31:16] are ignored.
- R3: In word mode (`cfg_word_mode`=1), an accepted write pushes two entries. The entry from `wr_data[15:0]` leaves the queue before the entry from `wr_data[31:16]`, and their codes are bits [11:0] and [27:16].
- R4: With `cfg_tag_en`=1, the channel of the first entry is `wr_data[13:12]` and the channel of the second entry is `wr_data[29:28]`.
- R5: With `cfg_tag_en`=0, every entry takes `cfg_def_chan` as its channel, whatever the tag bits hold.
- R6: The channel is fixed when the entry is pushed. Later changes to `cfg_tag_en` or `cfg_def_chan` do not alter entries already queued.
- R7: `tx_ready` is 0 whenever the queue holds DEPTH entries or `conv_enable`=0.
- R8: In word mode, `tx_ready` is 1 only when at least two entries are free.
- R9: A write with `tx_ready`=0 pushes nothing and sets `wr_error` on the next edge. `wr_error` then stays 1 until reset.
- R10: Entries leave in push order, one per cycle with `out_valid`=1 and `out_ready`=1. A push and a pop may happen in the same cycle. Acceptance of that push is judged on the occupancy before the pop.
- R11: While `out_valid`=1 and `out_ready`=0, `out_valid`, `out_code` and `out_chan` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Data port write strobe |
| wr_data | input | 32 | Data port write value |
| cfg_word_mode | input | 1 | 1: two entries per write; 0: one entry per write |
| cfg_tag_en | input | 1 | 1: channel taken from sample tag bits |
| cfg_def_chan | input | 2 | Default channel used when tags are off |
| conv_enable | input | 1 | Converter able to accept requests |
| tx_ready | output | 1 | A write now would be accepted |
| wr_error | output | 1 | Sticky flag: a write arrived while not ready |
| out_valid | output | 1 | Head entry available |
| out_ready | input | 1 | Sequencer takes the head entry |
| out_code | output | 12 | Head entry conversion code |
| out_chan | output | 2 | Head entry channel |

## Verification
The functions that can fall in the same cycle are a software push and a sequencer pop. The bench provokes this by raising `wr_en` and `out_ready` in the same cycle, once with three entries held and once with the queue full.

- With three entries held, the push must be accepted. The queue then holds the old second entry at its head, with the new entry at its tail.
- With the queue full, the pop must not open room for the write in that cycle. The write is refused, `wr_error` rises, and the drained sequence shows no trace of the refused sample.

// File: rtl/dsf_pkg.sv
package dsf_pkg;
    localparam int CODE_W = 12;
    localparam int CHAN_W = 2;
    localparam int HALF_W = 16;
    localparam int LANES  = 2;
    localparam int BUS_W  = HALF_W * LANES;

    typedef struct packed {
        logic [CHAN_W-1:0] chan;
        logic [CODE_W-1:0] code;
    } entry_t;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_PART  = 2'd1,
        ST_FULL  = 2'd2
    } fill_state_t;
endpackage

// File: rtl/dsf_unpack.sv
module dsf_unpack
    import dsf_pkg::*;
(
    input  logic [BUS_W-1:0]     wr_data,
    input  logic                 tag_en,
    input  logic [CHAN_W-1:0]    def_chan,
    output entry_t [LANES-1:0]   lane_ent
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_comb begin
            lane_ent[g].code = wr_data[g*HALF_W +: CODE_W];
            lane_ent[g].chan = tag_en ? wr_data[g*HALF_W + CODE_W +: CHAN_W]
                                      : def_chan;
        end
    end
endmodule

// File: rtl/dsf_fifo.sv
module dsf_fifo
    import dsf_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         push_n,
    input  entry_t [LANES-1:0] lane_ent,
    input  logic               pop,
    output entry_t             head
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    entry_t          mem [DEPTH];
    logic [AW-1:0]   wr_ptr;
    logic [AW-1:0]   rd_ptr;
    logic [AW-1:0]   wr_ptr_p1;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign wr_ptr_p1 = bump(wr_ptr);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push_n != 2'd0) begin
                mem[wr_ptr] <= lane_ent[0];
                if (push_n == 2'd2) begin
                    mem[wr_ptr_p1] <= lane_ent[1];
                    wr_ptr         <= bump(wr_ptr_p1);
                end else begin
                    wr_ptr         <= wr_ptr_p1;
                end
            end
            if (pop) begin
                rd_ptr <= bump(rd_ptr);
            end
        end
    end

    assign head = mem[rd_ptr];
endmodule

// File: rtl/dsf_ctrl.sv
module dsf_ctrl
    import dsf_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              wr_en,
    input  logic                              word_mode,
    input  logic                              conv_enable,
    input  logic                              out_ready,
    output logic [1:0]                        push_n,
    output logic                              pop,
    output logic                              tx_ready,
    output logic                              wr_error,
    output logic                              out_valid,
    output logic [$clog2(DEPTH+1)-1:0]        level
);
    localparam int CW = $clog2(DEPTH + 1);

    fill_state_t   state, state_nx;
    logic [CW-1:0] level_nx;
    logic [CW-1:0] free;
    logic [CW-1:0] need;
    logic          room;
    logic          accept;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_EMPTY;
            level    <= '0;
            wr_error <= 1'b0;
        end else begin
            state <= state_nx;
            level <= level_nx;
            if (wr_en && !tx_ready) begin
                wr_error <= 1'b1;
            end
        end
    end

    // Outputs decoded from state
    always_comb begin
        free = CW'(DEPTH) - level;
        need = word_mode ? CW'(2) : CW'(1);
        unique case (state)
            ST_EMPTY: begin
                out_valid = 1'b0;
                room      = (CW'(DEPTH) >= need);
            end
            ST_PART: begin
                out_valid = 1'b1;
                room      = (free >= need);
            end
            ST_FULL: begin
                out_valid = 1'b1;
                room      = 1'b0;
            end
            default: begin
                out_valid = 1'b0;
                room      = 1'b0;
            end
        endcase
        tx_ready = conv_enable && room;
        accept   = wr_en && tx_ready;
        push_n   = accept ? need[1:0] : 2'd0;
        pop      = out_valid && out_ready;
    end

    // Next-state logic
    always_comb begin
        level_nx = level + CW'(push_n) - CW'(pop);
        if (level_nx == '0) begin
            state_nx = ST_EMPTY;
        end else if (level_nx == CW'(DEPTH)) begin
            state_nx = ST_FULL;
        end else begin
            state_nx = ST_PART;
        end
    end
endmodule

// File: rtl/dac_sample_frontend.sv
module dac_sample_frontend
    import dsf_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    input  logic        cfg_word_mode,
    input  logic        cfg_tag_en,
    input  logic [1:0]  cfg_def_chan,
    input  logic        conv_enable,
    output logic        tx_ready,
    output logic        wr_error,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [11:0] out_code,
    output logic [1:0]  out_chan
);
    localparam int CW = $clog2(DEPTH + 1);

    entry_t [LANES-1:0] lane_ent;
    entry_t             head;
    logic [1:0]         push_n;
    logic               pop;
    logic [CW-1:0]      level;

    dsf_unpack u_unpack (
        .wr_data  (wr_data),
        .tag_en   (cfg_tag_en),
        .def_chan (cfg_def_chan),
        .lane_ent (lane_ent)
    );

    dsf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .word_mode   (cfg_word_mode),
        .conv_enable (conv_enable),
        .out_ready   (out_ready),
        .push_n      (push_n),
        .pop         (pop),
        .tx_ready    (tx_ready),
        .wr_error    (wr_error),
        .out_valid   (out_valid),
        .level       (level)
    );

    dsf_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .push_n   (push_n),
        .lane_ent (lane_ent),
        .pop      (pop),
        .head     (head)
    );

    assign out_code = head.code;
    assign out_chan = head.chan;
endmodule

// File: rtl/dsf_checker.sv
module dsf_checker #(
    parameter int DEPTH = 4
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       wr_en,
    input logic                       cfg_word_mode,
    input logic                       conv_enable,
    input logic                       tx_ready,
    input logic                       wr_error,
    input logic                       out_valid,
    input logic                       out_ready,
    input logic [11:0]                out_code,
    input logic [1:0]                 out_chan,
    input logic [$clog2(DEPTH+1)-1:0] level
);
    localparam int CW = $clog2(DEPTH + 1);

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!out_valid && !wr_error && level == '0));

    p_full_blocks_r7: assert property (@(posedge clk) disable iff (rst)
        (level == CW'(DEPTH)) |-> !tx_ready);

    p_conv_blocks_r7: assert property (@(posedge clk) disable iff (rst)
        !conv_enable |-> !tx_ready);

    p_word_room_r8: assert property (@(posedge clk) disable iff (rst)
        (cfg_word_mode && tx_ready) |-> (level <= CW'(DEPTH - 2)));

    p_err_set_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !tx_ready) |=> wr_error);

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        wr_error |=> wr_error);

    p_no_push_refused_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !tx_ready && !(out_valid && out_ready)) |=> $stable(level));

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
        level <= CW'(DEPTH));

    p_hold_head_r11: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_code) && $stable(out_chan)));
endmodule

bind dac_sample_frontend dsf_checker #(.DEPTH(DEPTH)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .wr_en         (wr_en),
    .cfg_word_mode (cfg_word_mode),
    .conv_enable   (conv_enable),
    .tx_ready      (tx_ready),
    .wr_error      (wr_error),
    .out_valid     (out_valid),
    .out_ready     (out_ready),
    .out_code      (out_code),
    .out_chan      (out_chan),
    .level         (level)
);

// File: tb/sim_dac_sample_frontend.sv
module sim_dac_sample_frontend;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        cfg_word_mode = 1'b0;
    logic        cfg_tag_en = 1'b0;
    logic [1:0]  cfg_def_chan = 2'd0;
    logic        conv_enable = 1'b1;
    logic        out_ready = 1'b0;
    logic        tx_ready, wr_error, out_valid;
    logic [11:0] out_code;
    logic [1:0]  out_chan;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dac_sample_frontend u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .cfg_word_mode(cfg_word_mode), .cfg_tag_en(cfg_tag_en),
        .cfg_def_chan(cfg_def_chan), .conv_enable(conv_enable),
        .tx_ready(tx_ready), .wr_error(wr_error), .out_valid(out_valid),
        .out_ready(out_ready), .out_code(out_code), .out_chan(out_chan)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        wr_en = 1'b0;
        out_ready = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic do_write(input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pop_check(input string req, input int code, input int chan);
        @(negedge clk);
        chk({req, " valid"}, out_valid, 1);
        chk({req, " code"}, out_code, code);
        chk({req, " chan"}, out_chan, chan);
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 valid", out_valid, 0);
        chk("R1 error", wr_error, 0);
        chk("R1 ready", tx_ready, 1);
    endtask

    task automatic t_half();
        cfg_word_mode = 1'b0;
        cfg_tag_en = 1'b0;
        cfg_def_chan = 2'd2;
        do_write(32'hABCD_F123);
        cfg_tag_en = 1'b1;
        do_write(32'h0000_3456);
        pop_check("R2 R5", 'h123, 2);
        pop_check("R4 half", 'h456, 3);
        chk("R2 single", out_valid, 0);
    endtask

    task automatic t_word();
        cfg_word_mode = 1'b1;
        cfg_tag_en = 1'b1;
        do_write(32'h2ABC_1DEF);
        pop_check("R3 first R4", 'hDEF, 1);
        pop_check("R3 second R4", 'hABC, 2);
        chk("R3 two only", out_valid, 0);
    endtask

    task automatic t_capture();
        cfg_word_mode = 1'b0;
        cfg_tag_en = 1'b0;
        cfg_def_chan = 2'd1;
        do_write(32'h0000_0777);
        cfg_def_chan = 2'd3;
        cfg_tag_en = 1'b1;
        pop_check("R6", 'h777, 1);
    endtask

    task automatic t_full();
        cfg_word_mode = 1'b0;
        cfg_tag_en = 1'b0;
        cfg_def_chan = 2'd0;
        for (int i = 1; i <= 4; i++) do_write(32'(i));
        chk("R7 full ready", tx_ready, 0);
        do_write(32'h0000_0FFF);
        chk("R9 error set", wr_error, 1);
        for (int i = 1; i <= 4; i++) pop_check("R9 contents", i, 0);
        @(negedge clk);
        chk("R9 no push", out_valid, 0);
        chk("R9 sticky", wr_error, 1);
        do_reset();
        chk("R1 R9 cleared", wr_error, 0);
    endtask

    task automatic t_word_room();
        cfg_word_mode = 1'b1;
        cfg_tag_en = 1'b0;
        cfg_def_chan = 2'd2;
        do_write(32'h0022_0011);
        cfg_word_mode = 1'b0;
        do_write(32'h0000_0033);
        chk("R8 half ready", tx_ready, 1);
        cfg_word_mode = 1'b1;
        @(negedge clk);
        chk("R8 word not ready", tx_ready, 0);
        cfg_word_mode = 1'b0;
        pop_check("R8 a", 'h011, 2);
        pop_check("R8 b", 'h022, 2);
        pop_check("R8 c", 'h033, 2);
    endtask

    task automatic t_conv();
        conv_enable = 1'b0;
        @(negedge clk);
        chk("R7 conv off", tx_ready, 0);
        conv_enable = 1'b1;
        @(negedge clk);
        chk("R7 conv on", tx_ready, 1);
    endtask

    task automatic t_simul();
        cfg_word_mode = 1'b0;
        cfg_tag_en = 1'b0;
        cfg_def_chan = 2'd1;
        for (int i = 1; i <= 3; i++) do_write(32'h0A0 + 32'(i));
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = 32'h0A4;
        out_ready = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        out_ready = 1'b0;
        chk("R10 accepted", wr_error, 0);
        for (int i = 2; i <= 4; i++) pop_check("R10 order", 'h0A0 + i, 1);
        @(negedge clk);
        chk("R10 empty", out_valid, 0);
        for (int i = 1; i <= 4; i++) do_write(32'h0B0 + 32'(i));
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = 32'h0BF;
        out_ready = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        out_ready = 1'b0;
        chk("R10 R9 refused", wr_error, 1);
        for (int i = 2; i <= 4; i++) pop_check("R10 full order", 'h0B0 + i, 1);
        @(negedge clk);
        chk("R10 no refused entry", out_valid, 0);
        do_reset();
    endtask

    task automatic t_hold();
        cfg_def_chan = 2'd3;
        cfg_tag_en = 1'b0;
        do_write(32'h0000_0555);
        do_write(32'h0000_0666);
        repeat (3) @(negedge clk);
        chk("R11 code held", out_code, 'h555);
        chk("R11 chan held", out_chan, 3);
        pop_check("R11 a", 'h555, 3);
        pop_check("R11 b", 'h666, 3);
    endtask

    initial begin
        t_reset();
        t_half();
        t_word();
        t_capture();
        t_full();
        t_word_room();
        t_conv();
        t_simul();
        t_hold();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R10 watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule